// File: doc/BRIEF.md
# Register-Mapped Bidirectional GPIO Port

This block gives a host eight general-purpose pins that it controls through two byte-wide registers on a small synchronous register bus. The port register holds the level that output pins drive. The mode register sets each pin on its own. A mode bit of 1 makes the pin an input. A mode bit of 0 makes it an output. Every pin comes out of the block as three signals: a drive value, an active-high drive enable and a sensed level. The pad tri-state buffer sits outside the block.

The host reads the port address to see the level present on each pin. An input pin returns its level after a two-flop synchronizer. An output pin returns the level it is driving. Both registers reset to all ones, so after reset every pin is an undriven input. No pin drives anything until the host clears mode bits.

Top module: `gpio_regport`

## Requirements
- R1: While reset is held, and just after it: the port and mode registers both hold 0xFF, every drive enable is 0, and the read data is 0x00.
- R2: `pin_oe[i]` is the inverse of mode bit i. Mode bit 1 means input and the drive is off. Mode bit 0 means output and the drive is on.
- R3: A write to address 0x02 loads the port register. From the next cycle, `pin_out` shows the new value.
- R4: A write to address 0x03 loads the mode register, and `pin_oe` changes in the next cycle. A pin switched to output drives the port bit that was already stored.
- R5: A read strobe at address 0x02 returns, in the cycle after the strobe, each input pin's level as seen through two synchronizer flops. A level held for two rising edges before the read edge is returned.
- R6: In a read of address 0x02, bits of output pins return the driven port register bit, whatever the external level is.
- R7: A read of address 0x03 returns the mode register.
- R8: A read of any address other than 0x02 or 0x03 returns 0x00. A write to such an address changes neither register.
- R9: `bus_rdata` keeps its value until the next read strobe. A read and a write to the same register in one cycle return the value from before the write.
- R10: `rst_n` resets the block as soon as it falls. Its rise is synchronized, so writes in the first two rising edges after the rise are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and releases synchronously |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe and held until the next read |
| pin_in | input | 8 | Level sensed at each pad |
| pin_out | output | 8 | Level each pad drives when enabled |
| pin_oe | output | 8 | Active-high drive enable per pad |

## Verification
Random mode masks split the pins between inputs and outputs. Random external levels are set on all pins, including those being driven, and each port read is compared with a merge of the two. This shows whether the synchronized pad level or the stored bit is returned for each pin. Random addresses outside the map check that stray reads return zero and stray writes have no effect. Directed cases cover the following:
- the all-ones reset state
- writes during the reset release window
- switching a pin to output with an already-stored bit
- a read and a write in the same cycle
- read data holding across idle cycles

// File: rtl/gpio_regport_pkg.sv
package gpio_regport_pkg;

  // Which register a bus address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PORT = 2'd1,
    SEL_MODE = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_regport_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] port_q,
  output logic [PIN_W-1:0] mode_q
);

  localparam logic [PIN_W-1:0] RESET_VAL = '1;

  logic             port_ce, mode_ce;
  logic [PIN_W-1:0] port_d, mode_d;

  always_comb begin
    port_ce = wr_en && (sel == SEL_PORT);
    mode_ce = wr_en && (sel == SEL_MODE);
    port_d  = port_ce ? wdata : port_q;
    mode_d  = mode_ce ? wdata : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= RESET_VAL;
      mode_q <= RESET_VAL;
    end else begin
      port_q <= port_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PIN_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_async,
  output logic [PIN_W-1:0] pin_sync
);

  logic [STAGES-1:0][PIN_W-1:0] stage_q;
  logic [STAGES-1:0][PIN_W-1:0] stage_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = pin_async;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_regport_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [PIN_W-1:0] port_q,
  input  logic [PIN_W-1:0] mode_q,
  input  logic [PIN_W-1:0] pin_sync,
  output logic [PIN_W-1:0] rdata_q
);

  logic [PIN_W-1:0] level;
  logic [PIN_W-1:0] rdata_d;

  // Per pin: an input returns its synchronized level, an output its driven bit
  for (genvar i = 0; i < PIN_W; i++) begin : g_level
    assign level[i] = mode_q[i] ? pin_sync[i] : port_q[i];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      unique case (sel)
        SEL_PORT: rdata_d = level;
        SEL_MODE: rdata_d = mode_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

endmodule

// File: rtl/gpio_regport.sv
module gpio_regport
  import gpio_regport_pkg::*;
#(
  parameter int             PIN_W     = 8,
  parameter int             ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h03,
  parameter int             SYNC_STG  = 2,
  parameter int             RST_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);

  logic             rst_core_n;
  reg_sel_e         sel;
  logic [PIN_W-1:0] port_q, mode_q, pin_sync;

  always_comb begin
    if (bus_addr == PORT_ADDR)      sel = SEL_PORT;
    else if (bus_addr == MODE_ADDR) sel = SEL_MODE;
    else                            sel = SEL_NONE;
  end

  gpio_rst_sync #(.STAGES(RST_STG)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  gpio_reg_bank #(.PIN_W(PIN_W)) bank_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .port_q (port_q),
    .mode_q (mode_q)
  );

  gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STG)) sync_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pin_async (pin_in),
    .pin_sync  (pin_sync)
  );

  gpio_read_port #(.PIN_W(PIN_W)) rdp_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_en    (bus_rd),
    .sel      (sel),
    .port_q   (port_q),
    .mode_q   (mode_q),
    .pin_sync (pin_sync),
    .rdata_q  (bus_rdata)
  );

  // Pad-side signals: a mode bit of 1 (input) turns the driver off
  for (genvar i = 0; i < PIN_W; i++) begin : g_pad
    assign pin_out[i] = port_q[i];
    assign pin_oe[i]  = ~mode_q[i];
  end

endmodule

// File: rtl/gpio_regport_chk.sv
module gpio_regport_chk #(
  parameter int             PIN_W     = 8,
  parameter int             ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h03
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [PIN_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [PIN_W-1:0]  bus_rdata,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);

  logic unmapped;
  assign unmapped = (bus_addr != PORT_ADDR) && (bus_addr != MODE_ADDR);

  a_r3_port_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_ADDR) |=> (pin_out == $past(bus_wdata)));

  a_r4_mode_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MODE_ADDR) |=> (pin_oe == ~$past(bus_wdata)));

  a_r6_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == PORT_ADDR) |=>
      (((bus_rdata ^ $past(pin_out)) & $past(pin_oe)) == '0));

  a_r7_mode_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == MODE_ADDR) |=> (bus_rdata == ~$past(pin_oe)));

  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_regport gpio_regport_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .MODE_ADDR(MODE_ADDR)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_regport_tb_top.sv
module gpio_regport_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in, pin_out, pin_oe;
  logic [7:0] ext;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [7:0] m_port, m_mode, m_rdata;

  always #2.5 clk = ~clk;

  // Pad model: a driven pad shows the driven level, otherwise the external one
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_regport dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] exp_port_read(logic [7:0] port, logic [7:0] mode,
                                               logic [7:0] lvl);
    return (~mode & port) | (mode & lvl);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h02) m_port = d;
    else if (a == 8'h03) m_mode = d;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h02) return exp_port_read(m_port, m_mode, ext);
    if (a == 8'h03) return m_mode;
    return 8'h00;
  endfunction

  task automatic check_pads(string req);
    check({req, " pin_out"}, pin_out, m_port);
    check({req, " pin_oe"}, pin_oe, ~m_mode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    ext = 8'hA5; m_port = 8'hFF; m_mode = 8'hFF;
    idle(3);
    // R1: reset state while reset is held
    check("R1 oe in reset", pin_oe, 8'h00);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    check("R1 out in reset", pin_out, 8'hFF);

    // R10: writes during the two synchronized-release edges are ignored
    rst_n = 1'b1;
    bus_addr = 8'h03; bus_wdata = 8'h00; bus_wr = 1'b1;
    idle(2);
    bus_wr = 1'b0;
    check("R10 write ignored on release", pin_oe, 8'h00);
    rd(8'h03, v);
    check("R10/R1 mode after release", v, 8'hFF);
    idle(2);
    rd(8'h02, v);
    check("R1/R5 all inputs read ext", v, 8'hA5);

    // R3/R4: store port bits first, then switch pins to output
    wr(8'h02, 8'h3C);
    check("R3 pin_out", pin_out, 8'h3C);
    check("R2 still undriven", pin_oe, 8'h00);
    wr(8'h03, 8'hF0);
    check("R4 oe after mode write", pin_oe, 8'h0F);
    check("R4 stored bit driven", pin_out & pin_oe, 8'h0C);
    idle(2);
    // R6: external level on driven pins is masked by the driven value
    ext = 8'hC3; idle(2);
    rd(8'h02, v);
    check("R6 mixed read", v, exp_port_read(m_port, m_mode, ext));
    rd(8'h03, v);
    check("R7 mode read", v, 8'hF0);

    // R9: rdata holds across idle cycles
    idle(4);
    check("R9 hold", bus_rdata, 8'hF0);
    // R9: read and write in the same cycle return the old value
    bus_addr = 8'h03; bus_wdata = 8'h5A; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; m_mode = 8'h5A;
    check("R9 read before write", bus_rdata, 8'hF0);
    check_pads("R2");
    idle(2);

    // R8: stray accesses
    wr(8'h04, 8'h00);
    check_pads("R8 unmapped write");
    rd(8'h01, v);
    check("R8 unmapped read", v, 8'h00);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 4);
      case (op)
        0: begin wr(8'h02, 8'($urandom)); check_pads("R3"); end
        1: begin wr(8'h03, 8'($urandom)); check_pads("R4"); idle(2); end
        2: begin ext = 8'($urandom); idle(2); end
        3: begin
             a = ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'(8'h02 + $urandom_range(0, 1));
             if (a != 8'h02 && a != 8'h03) begin wr(a, 8'($urandom)); check_pads("R8"); end
           end
        default: begin
             a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'(8'h02 + $urandom_range(0, 1));
             m_rdata = exp_read(a);
             rd(a, v);
             check("R5/R6/R7/R8 random read", v, m_rdata);
           end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule